// File: doc/BRIEF.md
# I2C Burst Transfer Controller

This block is the controller side of a two-wire serial bus. It runs one complete transaction for each start request. A write transaction sends the target's 7-bit device address with the direction bit clear, then a word address of one or two bytes, then between 1 and 16 data bytes, and finishes with STOP. A read transaction sends the same address header, issues a repeated START and the device address with the direction bit set, then receives between 1 and 16 bytes. It acknowledges every received byte except the last one, which it answers with NACK, and then it issues STOP.

The host loads all transaction parameters together with a one-cycle `start_i` pulse. Write bytes are fetched one at a time through a ready/valid handshake. While the block waits for a byte, SCL is held low. Each received byte is presented with a one-cycle valid strobe. A sticky NACK flag collects every target NACK seen during the transaction. If a NACK arrives on any address byte, the block issues STOP at once. SCL is driven push-pull. SDA is open-drain: the block only ever enables a low driver. Each bit time is made of four phases of equal length, derived from the system clock.

Top module: `i2c_burst_ctrl`

## Requirements
- R1: Each bit lasts four phases of `CLK_HZ/SCL_HZ/4` system cycles. SCL rises at the start of phase 1 and falls at the start of phase 3, so every SCL high pulse inside a transaction lasts exactly two phases. SCL idles high.
- R2: START pulls SDA low while SCL is high. STOP releases SDA while SCL is high. When no transaction is running, SCL is high and SDA is released.
- R3: Bytes go out most significant bit first. SDA is changed only at the start of phase 0, while SCL is low, and never during an SCL high pulse of a data or acknowledge bit.
- R4: A write puts START, `{dev_i,0}`, `word_i[15:8]` (only when `wide_i`=1), `word_i[7:0]`, the data bytes and STOP on the bus, in that order.
- R5: A read puts START, `{dev_i,0}`, the word address bytes as in R4, a repeated START and `{dev_i,1}` on the bus. It then receives the bytes, presents each one on `rdata_o` with a one-cycle `rvalid_o` in arrival order, and ends with STOP.
- R6: In a read, the controller drives a low (ACK) in the acknowledge slot of every received byte except the last, and leaves SDA high (NACK) after the last.
- R7: `len_i` holds the byte count minus one, so 0 moves one byte and 15 moves sixteen.
- R8: Before each write data byte, `wready_o` is raised and stays high until `wvalid_i`. The byte is taken on the cycle where both are high. SCL stays low for the whole wait, and the number of handshakes equals the byte count.
- R9: A target NACK on the device address or on a word address byte ends the transaction with STOP straight after that byte. It sets `nack_o`, and no later byte and no write request follows.
- R10: A target NACK on a write data byte sets `nack_o`, and the remaining data bytes are still sent.
- R11: `nack_o` stays set until the next accepted start, which clears it.
- R12: `done_o` is a one-cycle pulse in the cycle after STOP completes. A `start_i` that arrives while `busy_o` is high has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a transaction (taken only when idle) |
| read_i | input | 1 | 1 = read transaction, 0 = write transaction |
| wide_i | input | 1 | 1 = two-byte word address, 0 = one byte |
| dev_i | input | 7 | Target device address |
| word_i | input | 16 | Word address; the low byte alone is used when `wide_i`=0 |
| len_i | input | LEN_W (4) | Byte count minus one |
| wdata_i | input | 8 | Write data byte |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Controller ready to take a write byte |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| done_o | output | 1 | One-cycle strobe after STOP |
| nack_o | output | 1 | Sticky target-NACK flag |
| busy_o | output | 1 | Transaction in progress |
| scl_o | output | 1 | Serial clock, driven high and low |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| sda_i | input | 1 | Sensed SDA level |

## Verification
Some properties are checked by the assertions on every cycle:
- SDA stays still during SCL high pulses of data and acknowledge bits.
- START and STOP edges occur only under a high SCL, and the bus is released whenever the sequencer is idle.
- The done strobe lasts one cycle and the NACK flag stays set.
- The write handshake is raised only in write transactions, and only while SCL is parked low.

The bench's scenarios cover the rest. A behavioural target on the bus decodes the byte stream in the order it appears, NACKs chosen bytes, and supplies read data. The bench checks this ordering for both address widths, for burst lengths at both ends of the range, and for early STOP after an address NACK. It also checks the per-byte controller ACK/NACK pattern, that a data NACK does not shorten a burst, and that a start request during a busy transaction is ignored.

// File: rtl/i2c_burst_pkg.sv
`timescale 1ns/1ps
package i2c_burst_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {OP_START, OP_TX, OP_RX, OP_STOP} op_e;

  typedef enum logic [2:0] {E_IDLE, E_START, E_TX, E_RX, E_STOP} eng_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_AHI, S_ALO, S_WREQ,
    S_WDATA, S_RSTART, S_DEVR, S_RDATA, S_STOP
  } seq_e;
endpackage

// File: rtl/i2c_quarter_tick.sv
`timescale 1ns/1ps
module i2c_quarter_tick #(
  parameter int QUARTER = 62
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(QUARTER + 1);
  localparam logic [W-1:0] LAST = W'(QUARTER - 1);

  logic [W-1:0] cnt;

  // Counter rests at zero while the engine is idle so every op starts aligned.
  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  p_tick_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine
  import i2c_burst_pkg::*;
#(
  parameter int QUARTER = 62
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  op_e        op,
  input  logic [7:0] tx_byte,
  input  logic       ack_bit,   // 1 = answer received byte with NACK
  input  logic       sda_i,
  output logic       busy,
  output logic       fin,
  output logic       nack,
  output logic [7:0] rx_byte,
  output logic       scl,
  output logic       sda_oe
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

  eng_e       st;
  logic [1:0] ph;
  logic [3:0] slot;
  logic [7:0] tx_sh, rx_sh;
  logic       ack_q, scl_q, oe_q, fin_q, nack_q, tick;

  assign busy = (st != E_IDLE);

  i2c_quarter_tick #(.QUARTER(QUARTER)) u_tick (
    .clk(clk), .rst(rst), .en(busy), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; ph <= 2'd0; slot <= '0;
      tx_sh <= '0; rx_sh <= '0; ack_q <= 1'b1;
      scl_q <= 1'b1; oe_q <= 1'b0; fin_q <= 1'b0; nack_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (st == E_IDLE) begin
        if (go) begin
          ph <= 2'd0; slot <= '0; tx_sh <= tx_byte; ack_q <= ack_bit;
          case (op)
            OP_START: begin st <= E_START; oe_q <= 1'b0; end
            OP_STOP:  begin st <= E_STOP;  oe_q <= 1'b1; end
            OP_TX:    begin st <= E_TX; oe_q <= ~tx_byte[7]; nack_q <= 1'b0; end
            default:  begin st <= E_RX;    oe_q <= 1'b0; end
          endcase
        end
      end else if (tick) begin
        if (ph != 2'd3) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_q <= 1'b1;                       // phase 1: SCL up
            2'd1: begin                                // phase 2: sample / edge
              if (st == E_START)                       oe_q <= 1'b1;
              else if (st == E_STOP)                   oe_q <= 1'b0;
              else if (st == E_TX && slot == ACK_SLOT) nack_q <= sda_i;
              else if (st == E_RX && slot != ACK_SLOT) rx_sh <= {rx_sh[6:0], sda_i};
            end
            default: if (st != E_STOP) scl_q <= 1'b0; // phase 3: SCL down
          endcase
        end else if ((st == E_TX || st == E_RX) && slot != ACK_SLOT) begin
          ph   <= 2'd0;
          slot <= slot + 4'd1;
          if (slot == ACK_SLOT - 4'd1) begin
            oe_q <= (st == E_RX) ? ~ack_q : 1'b0;
          end else begin
            oe_q  <= (st == E_TX) ? ~tx_sh[6] : 1'b0;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end else begin
          st    <= E_IDLE;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin     = fin_q;
  assign nack    = nack_q;
  assign rx_byte = rx_sh;
  assign scl     = scl_q;
  assign sda_oe  = oe_q;

  // R3: SDA held through every SCL high pulse of a data/ack bit
  p_sda_steady_r3: assert property (@(posedge clk) disable iff (rst)
    ((st == E_TX || st == E_RX) && scl_q && $past(scl_q)) |-> $stable(oe_q));

  // R2: START falls and STOP rises only under high SCL
  p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_q) && st == E_START) |-> scl_q);
  p_stop_edge_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_q) && st == E_STOP) |-> scl_q);
endmodule

// File: rtl/i2c_burst_ctrl.sv
`timescale 1ns/1ps
module i2c_burst_ctrl
  import i2c_burst_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int SCL_HZ  = 400_000,
  parameter int MAX_LEN = 16,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             read_i,
  input  logic             wide_i,
  input  logic [6:0]       dev_i,
  input  logic [15:0]      word_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       wdata_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             done_o,
  output logic             nack_o,
  output logic             busy_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  localparam int QUARTER = CLK_HZ / SCL_HZ / 4;

  seq_e             st;
  logic             rd_q, wide_q, nack_q, wready_q, rvalid_q, done_q;
  logic [6:0]       dev_q;
  logic [15:0]      word_q;
  logic [LEN_W-1:0] left_q;
  logic [7:0]       rdata_q;
  logic             go_q, ackb_q;
  op_e              op_q;
  logic [7:0]       byte_q;
  logic             eng_busy, eng_fin, eng_nack;
  logic [7:0]       eng_rx;

  i2c_byte_engine #(.QUARTER(QUARTER)) u_engine (
    .clk(clk), .rst(rst), .go(go_q), .op(op_q), .tx_byte(byte_q),
    .ack_bit(ackb_q), .sda_i(sda_i), .busy(eng_busy), .fin(eng_fin),
    .nack(eng_nack), .rx_byte(eng_rx), .scl(scl_o), .sda_oe(sda_oe_o)
  );

  task automatic launch(input op_e o, input logic [7:0] b, input logic a);
    go_q <= 1'b1; op_q <= o; byte_q <= b; ackb_q <= a;
  endtask

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; rd_q <= 1'b0; wide_q <= 1'b0; nack_q <= 1'b0;
      wready_q <= 1'b0; rvalid_q <= 1'b0; done_q <= 1'b0;
      dev_q <= '0; word_q <= '0; left_q <= '0; rdata_q <= '0;
      go_q <= 1'b0; ackb_q <= 1'b1; op_q <= OP_START; byte_q <= '0;
    end else begin
      go_q <= 1'b0; rvalid_q <= 1'b0; done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          rd_q <= read_i; wide_q <= wide_i; dev_q <= dev_i;
          word_q <= word_i; left_q <= len_i; nack_q <= 1'b0;
          launch(OP_START, 8'h00, 1'b1);
          st <= S_START;
        end
        S_START: if (eng_fin) begin
          launch(OP_TX, {dev_q, 1'b0}, 1'b1); st <= S_DEVW;
        end
        S_DEVW: if (eng_fin) begin
          if (eng_nack)    begin nack_q <= 1'b1; launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else if (wide_q) begin launch(OP_TX, word_q[15:8], 1'b1); st <= S_AHI; end
          else             begin launch(OP_TX, word_q[7:0], 1'b1);  st <= S_ALO; end
        end
        S_AHI: if (eng_fin) begin
          if (eng_nack) begin nack_q <= 1'b1; launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else          begin launch(OP_TX, word_q[7:0], 1'b1); st <= S_ALO; end
        end
        S_ALO: if (eng_fin) begin
          if (eng_nack)  begin nack_q <= 1'b1; launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else if (rd_q) begin launch(OP_START, 8'h00, 1'b1); st <= S_RSTART; end
          else           begin wready_q <= 1'b1; st <= S_WREQ; end
        end
        S_WREQ: if (wvalid_i) begin
          wready_q <= 1'b0;
          launch(OP_TX, wdata_i, 1'b1);
          st <= S_WDATA;
        end
        S_WDATA: if (eng_fin) begin
          if (eng_nack) nack_q <= 1'b1;
          if (left_q == '0) begin launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else begin left_q <= left_q - 1'b1; wready_q <= 1'b1; st <= S_WREQ; end
        end
        S_RSTART: if (eng_fin) begin
          launch(OP_TX, {dev_q, 1'b1}, 1'b1); st <= S_DEVR;
        end
        S_DEVR: if (eng_fin) begin
          if (eng_nack) begin nack_q <= 1'b1; launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else          begin launch(OP_RX, 8'h00, left_q == '0); st <= S_RDATA; end
        end
        S_RDATA: if (eng_fin) begin
          rdata_q  <= eng_rx;
          rvalid_q <= 1'b1;
          if (left_q == '0) begin launch(OP_STOP, 8'h00, 1'b1); st <= S_STOP; end
          else begin
            left_q <= left_q - 1'b1;
            launch(OP_RX, 8'h00, left_q == LEN_W'(1));
          end
        end
        S_STOP: if (eng_fin) begin
          done_q <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wready_o = wready_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;
  assign nack_o   = nack_q;
  assign busy_o   = (st != S_IDLE);

  // R12: completion strobe lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R11: flag survives until a new start is accepted
  p_nack_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (nack_o && !(st == S_IDLE && start_i)) |=> nack_o);
  // R2: bus released whenever no transaction runs
  p_idle_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> (scl_o && !sda_oe_o));
  // R8: handshake only in writes, with SCL parked low and engine idle
  p_wready_write_r8: assert property (@(posedge clk) disable iff (rst)
    wready_o |-> (!rd_q && !eng_busy && !scl_o));
  // R5: read strobes only in read transactions
  p_rvalid_read_r5: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> rd_q);
endmodule

// File: tb/i2c_burst_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_burst_ctrl_bench;
  localparam int Q     = 5;
  localparam int EV_S  = 256;
  localparam int EV_P  = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, start_i, read_i, wide_i, wvalid_i;
  logic [6:0]  dev_i;
  logic [15:0] word_i;
  logic [3:0]  len_i;
  logic [7:0]  wdata_i;
  logic        wready_o, rvalid_o, done_o, nack_o, busy_o, scl_o, sda_oe_o;
  logic [7:0]  rdata_o;
  logic        tgt_pull;
  logic        sda_i;
  assign sda_i = !(sda_oe_o || tgt_pull);

  i2c_burst_ctrl #(.CLK_HZ(250_000_000), .SCL_HZ(12_500_000), .MAX_LEN(16)) u_i2c_burst_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .read_i(read_i), .wide_i(wide_i),
    .dev_i(dev_i), .word_i(word_i), .len_i(len_i), .wdata_i(wdata_i),
    .wvalid_i(wvalid_i), .wready_o(wready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .done_o(done_o), .nack_o(nack_o), .busy_o(busy_o), .scl_o(scl_o),
    .sda_oe_o(sda_oe_o), .sda_i(sda_i)
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_pattern(input int k);
    return 8'h5A ^ 8'(k * 37);
  endfunction

  // behavioural target and per-clock monitors
  int obs[$];
  int obs_ack[$];
  int prev_scl = 1, prev_sda = 1, bitc = 0, rx_n = 0, rd_k = 0, rv_k = 0;
  int nack_at = -1, hi_run = 0, done_cnt = 0;
  bit saw_rise = 0, first_byte = 0, pend_read = 0, reading = 0, ctrl_ack = 0;
  logic [7:0] sh = '0, cur_rb = '0;

  always @(negedge clk) begin
    if (!rst) begin
      int s, c;
      s = sda_i; c = scl_o;
      if (done_o) done_cnt++;
      if (rvalid_o) begin
        chk(rdata_o == rd_pattern(rv_k), "R5 read byte", rdata_o, rd_pattern(rv_k));
        rv_k++;
      end
      if (wready_o && scl_o) chk(0, "R8 SCL low while waiting", scl_o, 0);
      if (prev_scl && c && prev_sda && !s) begin
        obs.push_back(EV_S); bitc = 0; reading = 0; first_byte = 1; tgt_pull = 0;
      end else if (prev_scl && c && !prev_sda && s) begin
        obs.push_back(EV_P); bitc = 0; reading = 0; saw_rise = 0; tgt_pull = 0;
      end else if (!prev_scl && c) begin
        hi_run = 0; saw_rise = 1;
        if (bitc < 8) begin sh = {sh[6:0], s[0]}; bitc++; end
        else begin
          if (reading) begin obs_ack.push_back(s); ctrl_ack = s[0]; end
          bitc = 9;
        end
      end else if (prev_scl && !c) begin
        if (saw_rise) chk(hi_run == 2 * Q, "R1 SCL high width", hi_run, 2 * Q);
        saw_rise = 0;
        if (bitc == 8) begin
          if (reading) tgt_pull = 0;
          else begin
            obs.push_back(sh);
            tgt_pull = (rx_n != nack_at);
            pend_read = first_byte && sh[0] && (rx_n != nack_at);
            first_byte = 0;
            rx_n++;
          end
        end else if (bitc == 9) begin
          bitc = 0; tgt_pull = 0;
          if (pend_read) begin
            reading = 1; pend_read = 0; cur_rb = rd_pattern(rd_k); tgt_pull = !cur_rb[7];
          end else if (reading) begin
            if (!ctrl_ack) begin rd_k++; cur_rb = rd_pattern(rd_k); tgt_pull = !cur_rb[7]; end
            else reading = 0;
          end
        end else if (reading && bitc >= 1 && bitc <= 7) begin
          tgt_pull = !cur_rb[7 - bitc];
        end
      end
      if (c) hi_run++;
      prev_scl = c; prev_sda = s;
    end
  end

  // write-data supplier
  int wdelay = 0, wwait = 0, wsent = 0;
  logic [7:0] wbase = 8'h10;
  always @(negedge clk) begin
    if (!rst) begin
      if (wready_o && !wvalid_i) begin
        if (wwait >= wdelay) begin wvalid_i = 1'b1; wdata_i = wbase + 8'(wsent); end
        else wwait++;
      end else if (!wready_o && wvalid_i) begin
        wvalid_i = 1'b0; wsent++; wwait = 0;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_xfer(input bit rd, input bit wide, input logic [6:0] dev,
                          input logic [15:0] word, input int len, input int nidx,
                          input int dly, input bit poke_busy, input string tag);
    int exp_ev[$];
    int n, nreads, t;
    bit stopped, exp_nack;
    int hdr[$];
    exp_ev.delete(); hdr.delete();
    obs.delete(); obs_ack.delete();
    rx_n = 0; rd_k = 0; rv_k = 0; nack_at = nidx; wsent = 0; wwait = 0;
    wdelay = dly; done_cnt = 0;
    n = 0; stopped = 0; exp_nack = 0;
    exp_ev.push_back(EV_S);
    hdr.push_back({dev, 1'b0});
    if (wide) hdr.push_back(word[15:8]);
    hdr.push_back(word[7:0]);
    foreach (hdr[i]) begin
      if (!stopped) begin
        exp_ev.push_back(hdr[i]);
        if (n == nidx) begin stopped = 1; exp_nack = 1; end
        n++;
      end
    end
    if (!stopped && !rd) begin
      for (int i = 0; i < len; i++) begin
        exp_ev.push_back(int'(wbase + 8'(i)));
        if (n == nidx) exp_nack = 1;
        n++;
      end
    end else if (!stopped) begin
      exp_ev.push_back(EV_S);
      exp_ev.push_back({dev, 1'b1});
      if (n == nidx) begin stopped = 1; exp_nack = 1; end
      n++;
    end
    exp_ev.push_back(EV_P);
    nreads = (rd && !stopped) ? len : 0;

    @(negedge clk);
    start_i = 1; read_i = rd; wide_i = wide; dev_i = dev; word_i = word; len_i = 4'(len - 1);
    @(negedge clk);
    start_i = 0;
    t = 0;
    while (!done_o && t < 60000) begin
      @(negedge clk); t++;
      if (poke_busy && t == 400) begin
        start_i = 1; read_i = !rd; wide_i = !wide; dev_i = 7'h11; len_i = 4'd0;
      end else if (poke_busy && t == 401) start_i = 0;
    end
    chk(done_o == 1, {tag, " R12 done seen"}, done_o, 1);
    @(negedge clk);
    chk(!done_o, {tag, " R12 done one cycle"}, done_o, 0);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, {tag, " R12 single completion"}, done_cnt, 1);
    chk(!busy_o && scl_o && sda_i, {tag, " R2 bus idle after STOP"}, {busy_o, scl_o, sda_i}, 3'b011);
    chk(obs.size() == exp_ev.size(), {tag, " R4/R5/R9 event count"}, obs.size(), exp_ev.size());
    for (int i = 0; i < exp_ev.size() && i < obs.size(); i++)
      chk(obs[i] == exp_ev[i], {tag, " R3/R4/R5 bus event"}, obs[i], exp_ev[i]);
    chk(nack_o == exp_nack, {tag, " R9/R10/R11 nack flag"}, nack_o, exp_nack);
    chk(rv_k == nreads, {tag, " R5/R7 read strobes"}, rv_k, nreads);
    chk(wsent == ((!rd && !stopped) ? len : 0), {tag, " R8 write handshakes"}, wsent,
        (!rd && !stopped) ? len : 0);
    chk(obs_ack.size() == nreads, {tag, " R6 ack slot count"}, obs_ack.size(), nreads);
    for (int i = 0; i < obs_ack.size(); i++)
      chk(obs_ack[i] == int'(i == nreads - 1), {tag, " R6 controller ack level"},
          obs_ack[i], int'(i == nreads - 1));
  endtask

  initial begin
    rst = 1; start_i = 0; read_i = 0; wide_i = 0; dev_i = '0; word_i = '0;
    len_i = '0; wdata_i = '0; wvalid_i = 0; tgt_pull = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(scl_o && !sda_oe_o, "R2 reset bus state", {scl_o, sda_oe_o}, 2'b10);
    chk(!busy_o && !done_o && !nack_o && !wready_o && !rvalid_o, "R11 reset flags",
        {busy_o, done_o, nack_o, wready_o, rvalid_o}, 0);

    wbase = 8'h10; run_xfer(0, 0, 7'h50, 16'h0033, 3, -1, 0, 0, "R4 short write");
    wbase = 8'hC1; run_xfer(0, 1, 7'h2B, 16'hA55A, 1, -1, 25, 0, "R8 wide write slow data");
    run_xfer(1, 0, 7'h50, 16'h0007, 4, -1, 0, 0, "R5 read four");
    run_xfer(1, 1, 7'h63, 16'h1234, 1, -1, 0, 0, "R6 read single");
    wbase = 8'h80; run_xfer(0, 1, 7'h50, 16'hBEEF, 16, -1, 0, 0, "R7 write sixteen");
    run_xfer(1, 0, 7'h44, 16'h00F0, 16, -1, 0, 0, "R7 read sixteen");
    wbase = 8'h20; run_xfer(0, 0, 7'h12, 16'h0001, 2, 0, 0, 0, "R9 device nack");
    run_xfer(1, 1, 7'h12, 16'h4321, 2, 1, 0, 0, "R9 high address nack");
    run_xfer(1, 0, 7'h12, 16'h0099, 2, 2, 0, 0, "R9 read device nack");
    wbase = 8'h30; run_xfer(0, 0, 7'h3A, 16'h0040, 4, 3, 0, 0, "R10 data nack");
    wbase = 8'h40; run_xfer(0, 0, 7'h3A, 16'h0041, 2, -1, 0, 0, "R11 flag cleared");
    wbase = 8'h55; run_xfer(0, 1, 7'h70, 16'h0102, 5, -1, 0, 1, "R12 start while busy");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule